// File: doc/BRIEF.md
# Integer ALU with Operation Decode

This block is the integer arithmetic and logic unit of a 32-bit RISC-V style execute stage. It takes two operands, a 3-bit function code and a 7-bit secondary function code straight from the instruction fields, plus a flag telling it whether the instruction is the register-immediate form. It decodes those fields into one operation, computes the result and flags encodings that it does not support. In the immediate form the caller places the sign-extended immediate on operand B. Bit 10 of that immediate still selects an arithmetic right shift.

The secondary code 0000001 marks the product and quotient group, which another unit executes. This block accepts that code without flagging it and returns zero. Whenever the illegal flag is raised the result is forced to zero as well. With the parameter `OUT_REG` set to 1 (the default), result and flag go through one register stage that an active-low asynchronous reset clears. With `OUT_REG` set to 0 the block is purely combinational.

Top module: `rv_int_alu`

## Requirements
- R1: Function code 000 adds, 100 XORs, 110 ORs and 111 ANDs the operands, in both forms. The add wraps modulo 2^32, for example FFFFFFFF + 2 = 00000001.
- R2: Function code 010 returns 1 when A < B as two's-complement values and 0 otherwise. Function code 011 does the same comparison on unsigned values. Bits 31..1 of the result are always 0.
- R3: In register form, secondary code 0100000 with function code 000 gives A - B modulo 2^32. Secondary code 0000000 with function code 000 gives A + B.
- R4: Function code 001 shifts A left by B[4:0] in both forms. B[31:5] have no effect on the result.
- R5: Function code 101 shifts A right by B[4:0]. In register form, secondary code 0000000 makes the shift logical and 0100000 makes it arithmetic (sign-filling). In immediate form, B[10]=1 makes it arithmetic and B[10]=0 makes it logical.
- R6: In register form, a secondary code other than 0000000, 0100000 and 0000001 sets illegal to 1 and the result to 0.
- R7: In register form, secondary code 0100000 with any function code other than 000 and 101 sets illegal to 1 and the result to 0.
- R8: In register form, secondary code 0000001 leaves illegal at 0 and gives result 0.
- R9: In immediate form the illegal flag is never set, and the secondary code has no effect on the result.
- R10: With `OUT_REG`=1, the result and illegal flag for the inputs present at a rising clock edge appear after that edge. While reset is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the sign-extended immediate in immediate form |
| fn3 | input | 3 | Primary function code |
| fn7 | input | 7 | Secondary function code, used in register form only |
| imm_form | input | 1 | 1 selects the register-immediate form |
| result | output | 32 | Operation result |
| illegal | output | 1 | 1 when the encoding is unsupported |

## Verification
The assertions take for granted that every input is driven to a known value on each cycle outside reset. They also assume that, in the registered build, inputs change only between clock edges, so the pipe property relates each output to the decode of the previous cycle. The stimulus keeps to this in two ways. All inputs are set before reset is released and are then changed only on falling edges. Register-form vectors draw their secondary code from the three accepted values and from a few unsupported ones, so the illegal properties and the arithmetic properties are both exercised.

// File: rtl/rv_alu_pkg.sv
`timescale 1ns/1ps
package rv_alu_pkg;
  localparam int F3_W = 3;
  localparam int F7_W = 7;

  localparam logic [F7_W-1:0] F7_BASE   = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT    = 7'b0100000;
  localparam logic [F7_W-1:0] F7_PRODQ  = 7'b0000001;

  typedef enum logic [3:0] {
    OP_ZERO, OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
  } alu_op_e;

  // common mapping of the primary code; alt_shift picks the sign-filling right shift
  function automatic alu_op_e map_fn3(input logic [F3_W-1:0] f3, input logic alt_shift);
    case (f3)
      3'b000:  return OP_ADD;
      3'b001:  return OP_SLL;
      3'b010:  return OP_SLT;
      3'b011:  return OP_SLTU;
      3'b100:  return OP_XOR;
      3'b101:  return alt_shift ? OP_SRA : OP_SRL;
      3'b110:  return OP_OR;
      default: return OP_AND;
    endcase
  endfunction
endpackage

// File: rtl/rv_alu_decode.sv
`timescale 1ns/1ps
module rv_alu_decode
  import rv_alu_pkg::*;
#(
  parameter int W            = 32,
  parameter int IMM_SRA_BIT  = 10
) (
  input  logic [F3_W-1:0] fn3,
  input  logic [F7_W-1:0] fn7,
  input  logic            imm_form,
  input  logic [W-1:0]    imm_val,
  output alu_op_e         op,
  output logic            bad_enc
);
  logic imm_arith;
  assign imm_arith = imm_val[IMM_SRA_BIT];

  always_comb begin
    op      = OP_ZERO;
    bad_enc = 1'b0;
    if (imm_form) begin
      op = map_fn3(fn3, imm_arith);
    end else if (fn7 == F7_PRODQ) begin
      op = OP_ZERO;
    end else if (fn7 == F7_BASE) begin
      op = map_fn3(fn3, 1'b0);
    end else if (fn7 == F7_ALT) begin
      case (fn3)
        3'b000:  op = OP_SUB;
        3'b101:  op = OP_SRA;
        default: bad_enc = 1'b1;
      endcase
    end else begin
      bad_enc = 1'b1;
    end
  end
endmodule

// File: rtl/rv_alu_datapath.sv
`timescale 1ns/1ps
module rv_alu_datapath
  import rv_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         kill,
  output logic [W-1:0] y
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] shr_fn(input logic [W-1:0] v,
                                          input logic [SHW-1:0] amt,
                                          input logic fill_sign);
    logic signed [W:0] ext;
    ext = $signed({fill_sign & v[W-1], v});
    ext = ext >>> amt;
    return ext[W-1:0];
  endfunction

  function automatic logic less_fn(input logic [W-1:0] x,
                                   input logic [W-1:0] z,
                                   input logic sgn);
    logic [W:0] xe, ze;
    xe = {sgn & x[W-1], x};
    ze = {sgn & z[W-1], z};
    return $signed(xe) < $signed(ze);
  endfunction

  logic [SHW-1:0] shamt;
  logic [W-1:0]   raw;
  assign shamt = b[SHW-1:0];

  always_comb begin
    case (op)
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_SLL:  raw = a << shamt;
      OP_SLT:  raw = {{(W-1){1'b0}}, less_fn(a, b, 1'b1)};
      OP_SLTU: raw = {{(W-1){1'b0}}, less_fn(a, b, 1'b0)};
      OP_XOR:  raw = a ^ b;
      OP_SRL:  raw = shr_fn(a, shamt, 1'b0);
      OP_SRA:  raw = shr_fn(a, shamt, 1'b1);
      OP_OR:   raw = a | b;
      OP_AND:  raw = a & b;
      default: raw = '0;
    endcase
  end

  assign y = kill ? '0 : raw;
endmodule

// File: rtl/rv_alu_outstage.sv
`timescale 1ns/1ps
module rv_alu_outstage #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_res,
  input  logic         d_bad,
  output logic [W-1:0] q_res,
  output logic         q_bad
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_res <= '0;
          q_bad <= 1'b0;
        end else begin
          q_res <= d_res;
          q_bad <= d_bad;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_res = d_res;
      assign q_bad = d_bad;
    end
  endgenerate
endmodule

// File: rtl/rv_int_alu.sv
`timescale 1ns/1ps
module rv_int_alu
  import rv_alu_pkg::*;
#(
  parameter int W           = 32,
  parameter int IMM_SRA_BIT = 10,
  parameter bit OUT_REG     = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [F3_W-1:0] fn3,
  input  logic [F7_W-1:0] fn7,
  input  logic            imm_form,
  output logic [W-1:0]    result,
  output logic            illegal
);
  alu_op_e      core_op;
  logic         core_illegal;
  logic [W-1:0] core_result;

  rv_alu_decode #(.W(W), .IMM_SRA_BIT(IMM_SRA_BIT)) dec_i (
    .fn3(fn3), .fn7(fn7), .imm_form(imm_form), .imm_val(opnd_b),
    .op(core_op), .bad_enc(core_illegal)
  );

  rv_alu_datapath #(.W(W)) dp_i (
    .a(opnd_a), .b(opnd_b), .op(core_op), .kill(core_illegal), .y(core_result)
  );

  rv_alu_outstage #(.W(W), .OUT_REG(OUT_REG)) out_i (
    .clk(clk), .rst_n(rst_n), .d_res(core_result), .d_bad(core_illegal),
    .q_res(result), .q_bad(illegal)
  );
endmodule

// File: rtl/rv_int_alu_chk.sv
`timescale 1ns/1ps
module rv_int_alu_chk
  import rv_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    opnd_a,
  input logic [W-1:0]    opnd_b,
  input logic [F3_W-1:0] fn3,
  input logic [F7_W-1:0] fn7,
  input logic            imm_form,
  input logic            core_illegal,
  input logic [W-1:0]    core_result,
  input logic [W-1:0]    result,
  input logic            illegal
);
  logic f7_known;
  assign f7_known = (fn7 == F7_BASE) || (fn7 == F7_ALT) || (fn7 == F7_PRODQ);

  AST_UNKNOWN_F7_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_form && !f7_known) |-> core_illegal); // R6

  AST_ALT_F7_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_form && fn7 == F7_ALT && fn3 != 3'b000 && fn3 != 3'b101) |-> core_illegal); // R7

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    core_illegal |-> (core_result == '0)); // R6

  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_form && fn7 == F7_ALT && fn3 == 3'b000) |-> (core_result + opnd_b == opnd_a)); // R3

  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (fn3 == 3'b010 || fn3 == 3'b011) |-> (core_result[W-1:1] == '0)); // R2

  AST_IMM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    imm_form |-> !core_illegal); // R9

  AST_PRODQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_form && fn7 == F7_PRODQ) |-> (!core_illegal && core_result == '0)); // R8

  generate
    if (OUT_REG) begin : g_pipe
      AST_OUT_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result == $past(core_result) && illegal == $past(core_illegal))); // R10
    end else begin : g_flow
      AST_OUT_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (result == core_result && illegal == core_illegal)); // R10
    end
  endgenerate
endmodule

bind rv_int_alu rv_int_alu_chk #(.W(W), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .fn3(fn3),
  .fn7(fn7), .imm_form(imm_form), .core_illegal(core_illegal),
  .core_result(core_result), .result(result), .illegal(illegal)
);

// File: tb/rv_int_alu_tb_top.sv
`timescale 1ns/1ps
module rv_int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [2:0]  fn3 = '0;
  logic [6:0]  fn7 = '0;
  logic        imm_form = 1'b0;
  logic [31:0] result;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp_res;
    logic        exp_ill;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  rv_int_alu dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .fn3(fn3),
    .fn7(fn7), .imm_form(imm_form), .result(result), .illegal(illegal)
  );

  // reference model written from the requirements: returns {illegal, result}
  function automatic logic [32:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] f3, input logic [6:0] f7,
                                            input logic imf);
    logic [31:0] r;
    int sh;
    logic arith;
    sh = int'(b & 32'h1f);
    if (!imf && f7 == 7'h01) return 33'd0;
    if (!imf && f7 != 7'h00 && f7 != 7'h20) return {1'b1, 32'd0};
    if (!imf && f7 == 7'h20 && f3 != 3'd0 && f3 != 3'd5) return {1'b1, 32'd0};
    arith = imf ? b[10] : (f7 == 7'h20);
    case (f3)
      3'd0: r = (!imf && f7 == 7'h20) ? a + (~b + 32'd1) : a + b;
      3'd1: begin r = a; for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0}; end
      3'd2: r = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? 32'd1 : 32'd0;
      3'd3: r = (a < b) ? 32'd1 : 32'd0;
      3'd4: r = a ^ b;
      3'd5: begin
        r = a;
        for (int i = 0; i < sh; i++) r = {arith & r[31], r[31:1]};
      end
      3'd6: r = a | b;
      default: r = a & b;
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [2:0] f3, input logic [6:0] f7, input logic imf);
    if (imf) return "R9";
    if (f7 == 7'h01) return "R8";
    if (f7 == 7'h20) return (f3 == 3'd0) ? "R3" : (f3 == 3'd5) ? "R5" : "R7";
    if (f7 != 7'h00) return "R6";
    case (f3)
      3'd1: return "R4";
      3'd2, 3'd3: return "R2";
      3'd5: return "R5";
      default: return "R1";
    endcase
  endfunction

  // driver: applies one vector at a falling edge and queues its expectation
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f3,
                       input logic [6:0] f7, input logic imf, input string tag);
    logic [32:0] e;
    sb_item_t it;
    @(negedge clk);
    opnd_a = a; opnd_b = b; fn3 = f3; fn7 = f7; imm_form = imf;
    e = ref_model(a, b, f3, f7, imf);
    it.exp_res = e[31:0];
    it.exp_ill = e[32];
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: the value captured at each rising edge is compared just after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        total++;
        if (result !== it.exp_res || illegal !== it.exp_ill) begin
          bad++;
          $display("FAIL %s result=%h exp=%h illegal=%b exp=%b",
                   it.tag, result, it.exp_res, illegal, it.exp_ill);
        end
      end
    end
  end

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog result=%h exp=done illegal=%b exp=0", result, illegal);
    finish_run();
  end

  initial begin
    // R10: outputs held at zero during reset even with active inputs
    opnd_a = 32'h1234_5678; opnd_b = 32'h1111_1111; fn3 = 3'd6;
    repeat (3) @(negedge clk);
    total++;
    if (result !== 32'd0 || illegal !== 1'b0) begin
      bad++;
      $display("FAIL R10 result=%h exp=00000000 illegal=%b exp=0", result, illegal);
    end
    rst_n = 1'b1;

    drive(32'hFFFF_FFFF, 32'h2, 3'd0, 7'h00, 1'b0, "R1");
    drive(32'h7FFF_FFFF, 32'h1, 3'd0, 7'h00, 1'b1, "R1");
    drive(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'd4, 7'h00, 1'b0, "R1");
    drive(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'd6, 7'h00, 1'b1, "R1");
    drive(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'd7, 7'h00, 1'b0, "R1");
    drive(32'hFFFF_FFFF, 32'h1, 3'd2, 7'h00, 1'b0, "R2");
    drive(32'hFFFF_FFFF, 32'h1, 3'd3, 7'h00, 1'b0, "R2");
    drive(32'h5, 32'h5, 3'd2, 7'h00, 1'b1, "R2");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'd2, 7'h00, 1'b1, "R2");
    drive(32'h5, 32'h7, 3'd0, 7'h20, 1'b0, "R3");
    drive(32'h0, 32'h1, 3'd0, 7'h20, 1'b0, "R3");
    drive(32'h0000_0003, 32'hFFFF_FFE1, 3'd1, 7'h00, 1'b0, "R4");
    drive(32'h8000_0001, 32'h0000_001F, 3'd1, 7'h00, 1'b1, "R4");
    drive(32'h8000_0000, 32'h4, 3'd5, 7'h00, 1'b0, "R5");
    drive(32'h8000_0000, 32'h4, 3'd5, 7'h20, 1'b0, "R5");
    drive(32'h8000_0000, 32'h0000_0404, 3'd5, 7'h00, 1'b1, "R5");
    drive(32'h8000_0000, 32'h0000_0004, 3'd5, 7'h00, 1'b1, "R5");
    drive(32'hC000_0000, 32'hFFFF_FFFF, 3'd5, 7'h00, 1'b1, "R5");
    drive(32'h1, 32'h1, 3'd0, 7'h10, 1'b0, "R6");
    drive(32'h1, 32'h1, 3'd4, 7'h20, 1'b0, "R7");
    drive(32'h1, 32'h1, 3'd1, 7'h20, 1'b0, "R7");
    drive(32'h6, 32'h7, 3'd0, 7'h01, 1'b0, "R8");
    drive(32'h10, 32'h5, 3'd0, 7'h55, 1'b1, "R9");

    for (int n = 0; n < 400; n++) begin
      logic [6:0] f7;
      logic [2:0] f3;
      logic imf;
      case ($urandom % 6)
        0, 1: f7 = 7'h00;
        2:    f7 = 7'h20;
        3:    f7 = 7'h01;
        default: f7 = 7'($urandom);
      endcase
      f3 = 3'($urandom);
      imf = ($urandom % 3) == 0;
      drive($urandom, $urandom, f3, f7, imf, tag_of(f3, f7, imf));
    end

    repeat (3) @(negedge clk);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R10 result=%0d pending exp=0 pending", sb_q.size());
    end
    finish_run();
  end
endmodule